// File: doc/BRIEF.md
# Parallel Slave Host Port

This block lets an external master processor exchange bytes with the local core over an 8-bit parallel bus. The master drives an active-low chip select, active-low read and write strobes and an address-latch/select input. One address select bit picks between two register pairs. With select 0 the master writes a data-in byte and reads a data-out byte. With select 1 it writes a command byte and reads a status byte. An active-high interrupt line runs back to the master.

The bus works in one of two modes. In multiplexed mode, bus bit 1 carries the select during an address phase, and it is latched while the latch input is high. In demultiplexed mode, the latch input is itself the select and the bus carries only data. All bus inputs are brought into the core clock through a two-flop synchronizer, and strobe edges are detected in the core clock domain.

On the core side, a small register port gives the core access. Core address 0 writes the data-out byte and reads the data-in byte. Address 1 reads the command byte. Address 2 is a control register that sets the interrupt and clears the command-pending flag, and it reads back the status.

Top module: `hsp_port`

## Requirements
- R1: After reset, host_irq is 0, bus_oe is 0 while the bus is idle, core_rdata is 0, and the core status read (address 2) is 0.
- R2: While bus_cs_n is high, read and write strobes change no register and no flag. This includes the data-ready flag.
- R3: With select 0, a write strobe rising edge while chip select is low stores the bus byte in the data-in register. The core reads that register at address 0.
- R4: With select 1, a write strobe rising edge while chip select is low stores the bus byte in the command register and sets the command-pending flag. The core reads the command register at address 1. The flag is status bit 1.
- R5: In multiplexed mode (mux_mode=1), bus bit 1 is latched while bus_ale is high, and that latched value is the select. The data phase value of bit 1 has no effect on the select.
- R6: In demultiplexed mode (mux_mode=0), the level of bus_ale is the select.
- R7: While chip select and read are both low, bus_dout shows the data-out register (select 0) or the status byte (select 1) within 4 clocks of the read falling edge. The status byte holds data-ready in bit 0, command-pending in bit 1 and interrupt in bit 2. All other bits are 0.
- R8: bus_oe is 1 exactly while bus_cs_n and bus_rd_n are both low.
- R9: A core write to address 0 loads the data-out register and sets data-ready. A master read falling edge with select 0 and chip select low clears data-ready.
- R10: A core write to address 2 sets host_irq to write bit 0. When write bit 1 is 1, the same write clears command-pending.
- R11: core_rdata presents the register chosen by core_addr one clock after the address is applied. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| mux_mode | input | 1 | 1 = multiplexed address/data bus, 0 = demultiplexed |
| bus_cs_n | input | 1 | Chip select from master, active low |
| bus_rd_n | input | 1 | Read strobe from master, active low |
| bus_wr_n | input | 1 | Write strobe from master, active low |
| bus_ale | input | 1 | Address latch enable (multiplexed) or select (demultiplexed) |
| bus_din | input | DW | Bus value seen at the pads |
| bus_dout | output | DW | Byte driven toward the master during reads |
| bus_oe | output | 1 | Tri-state enable for bus_dout |
| host_irq | output | 1 | Interrupt to master, active high |
| core_addr | input | 2 | Core register address |
| core_wr | input | 1 | Core write enable |
| core_wdata | input | DW | Core write data |
| core_rdata | output | DW | Core read data, registered |

## Verification
Some behaviours are checked by assertions on every cycle. A write event lands in exactly one of the data-in and command registers, and only when chip select was seen active during the strobe. Those registers hold their value whenever no write event occurs. Core writes set data-ready and drive the interrupt on the next clock. Other behaviours only the bench scenarios can show. These include how the select is decoded in each bus mode, the masking of bus bit 1 after the address phase, the bytes that appear on the bus during reads, and the fact that strobes outside chip select leave all state as it was.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  localparam int DW_DEFAULT = 8;
  localparam logic [1:0] CA_DATA = 2'd0;
  localparam logic [1:0] CA_CMD  = 2'd1;
  localparam logic [1:0] CA_CTRL = 2'd2;
  localparam int ST_READY = 0;
  localparam int ST_PEND  = 1;
  localparam int ST_IRQ   = 2;
  localparam int CT_IRQ   = 0;
  localparam int CT_CLR   = 1;
endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RST_VAL;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hsp_strobe.sv
module hsp_strobe #(
  parameter int DW = 8,
  parameter int ADDR_BIT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mux_mode,
  input  logic          s_cs_n,
  input  logic          s_rd_n,
  input  logic          s_wr_n,
  input  logic          s_ale,
  input  logic [DW-1:0] s_din,
  output logic          wr_data_ev,
  output logic          wr_cmd_ev,
  output logic [DW-1:0] wr_byte,
  output logic          rd_data_ev,
  output logic          cur_sel
);
  logic          addr_lat;
  logic          wr_prev, rd_prev;
  logic [DW-1:0] hold_data;
  logic          hold_sel, hold_cs;
  logic          wr_rise, rd_fall;

  assign cur_sel = mux_mode ? addr_lat : s_ale;
  assign wr_rise = s_wr_n && !wr_prev;
  assign rd_fall = !s_rd_n && rd_prev && !s_cs_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_lat   <= 1'b0;
      wr_prev    <= 1'b1;
      rd_prev    <= 1'b1;
      hold_data  <= '0;
      hold_sel   <= 1'b0;
      hold_cs    <= 1'b0;
      wr_data_ev <= 1'b0;
      wr_cmd_ev  <= 1'b0;
      wr_byte    <= '0;
      rd_data_ev <= 1'b0;
    end else begin
      wr_prev <= s_wr_n;
      rd_prev <= s_rd_n;
      if (mux_mode && s_ale) addr_lat <= s_din[ADDR_BIT];
      if (!s_wr_n) begin
        hold_data <= s_din;
        hold_sel  <= cur_sel;
        hold_cs   <= !s_cs_n;
      end
      wr_data_ev <= wr_rise && hold_cs && !hold_sel;
      wr_cmd_ev  <= wr_rise && hold_cs && hold_sel;
      if (wr_rise) wr_byte <= hold_data;
      rd_data_ev <= rd_fall && !cur_sel;
    end
  end

  p_wr_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(wr_data_ev && wr_cmd_ev));
  p_cs_gate_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_data_ev || wr_cmd_ev) |-> $past(hold_cs));
endmodule

// File: rtl/hsp_port.sv
module hsp_port #(
  parameter int DW = hsp_pkg::DW_DEFAULT,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_BIT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mux_mode,
  input  logic          bus_cs_n,
  input  logic          bus_rd_n,
  input  logic          bus_wr_n,
  input  logic          bus_ale,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  output logic          host_irq,
  input  logic [1:0]    core_addr,
  input  logic          core_wr,
  input  logic [DW-1:0] core_wdata,
  output logic [DW-1:0] core_rdata
);
  import hsp_pkg::*;

  localparam int SW = DW + 4;
  localparam logic [SW-1:0] SYNC_RST = {4'b1110, {DW{1'b0}}};

  logic [SW-1:0] s_bus;
  logic          s_cs_n, s_rd_n, s_wr_n, s_ale;
  logic [DW-1:0] s_din;

  hsp_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst),
    .d({bus_cs_n, bus_rd_n, bus_wr_n, bus_ale, bus_din}),
    .q(s_bus)
  );
  assign {s_cs_n, s_rd_n, s_wr_n, s_ale, s_din} = s_bus;

  logic          wr_data_ev, wr_cmd_ev, rd_data_ev, cur_sel;
  logic [DW-1:0] wr_byte;

  hsp_strobe #(.DW(DW), .ADDR_BIT(ADDR_BIT)) u_strobe (
    .clk(clk), .rst(rst), .mux_mode(mux_mode),
    .s_cs_n(s_cs_n), .s_rd_n(s_rd_n), .s_wr_n(s_wr_n), .s_ale(s_ale),
    .s_din(s_din),
    .wr_data_ev(wr_data_ev), .wr_cmd_ev(wr_cmd_ev), .wr_byte(wr_byte),
    .rd_data_ev(rd_data_ev), .cur_sel(cur_sel)
  );

  logic [DW-1:0] din_reg, cmd_reg, dout_reg, status;
  logic          ready, pend, irq_r;
  logic          cw_data, cw_ctrl;

  assign cw_data = core_wr && (core_addr == CA_DATA);
  assign cw_ctrl = core_wr && (core_addr == CA_CTRL);

  always_comb begin
    status = '0;
    status[ST_READY] = ready;
    status[ST_PEND]  = pend;
    status[ST_IRQ]   = irq_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      din_reg  <= '0;
      cmd_reg  <= '0;
      dout_reg <= '0;
      ready    <= 1'b0;
      pend     <= 1'b0;
      irq_r    <= 1'b0;
    end else begin
      if (wr_data_ev) din_reg <= wr_byte;
      if (wr_cmd_ev)  cmd_reg <= wr_byte;
      if (cw_data) dout_reg <= core_wdata;
      if (cw_data) ready <= 1'b1;
      else if (rd_data_ev) ready <= 1'b0;
      if (wr_cmd_ev) pend <= 1'b1;
      else if (cw_ctrl && core_wdata[CT_CLR]) pend <= 1'b0;
      if (cw_ctrl) irq_r <= core_wdata[CT_IRQ];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_dout   <= '0;
      core_rdata <= '0;
    end else begin
      bus_dout <= cur_sel ? status : dout_reg;
      case (core_addr)
        CA_DATA: core_rdata <= din_reg;
        CA_CMD:  core_rdata <= cmd_reg;
        CA_CTRL: core_rdata <= status;
        default: core_rdata <= '0;
      endcase
    end
  end

  assign bus_oe   = !bus_cs_n && !bus_rd_n;
  assign host_irq = irq_r;

  p_ready_set_r9: assert property (@(posedge clk) disable iff (rst)
    cw_data |=> ready);
  p_pend_set_r4: assert property (@(posedge clk) disable iff (rst)
    wr_cmd_ev |=> pend);
  p_cmd_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !wr_cmd_ev |=> $stable(cmd_reg));
  p_din_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_data_ev |=> $stable(din_reg));
  p_irq_ctrl_r10: assert property (@(posedge clk) disable iff (rst)
    cw_ctrl |=> (host_irq == $past(core_wdata[CT_IRQ])));
endmodule

// File: tb/sim_hsp_port.sv
module sim_hsp_port;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 19;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mux_mode = 1'b0;
  logic       bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1, bus_ale = 1'b0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout;
  logic       bus_oe, host_irq;
  logic [1:0] core_addr = '0;
  logic       core_wr = 1'b0;
  logic [7:0] core_wdata = '0;
  logic [7:0] core_rdata;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsp_port u0 (
    .clk(clk), .rst(rst), .mux_mode(mux_mode),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_ale(bus_ale), .bus_din(bus_din), .bus_dout(bus_dout),
    .bus_oe(bus_oe), .host_irq(host_irq),
    .core_addr(core_addr), .core_wr(core_wr),
    .core_wdata(core_wdata), .core_rdata(core_rdata)
  );

  // op: 0 master write, 1 master read, 2 core write, 3 core read
  // fields: op[25:23] mux[22] sel[21:20] data[19:12] exp[11:4] req[3:0]
  localparam logic [25:0] VEC [NV] = '{
    {3'd2, 1'b0, 2'd0, 8'hA5, 8'h00, 4'd9},  // R9 core loads data-out
    {3'd1, 1'b0, 2'd1, 8'h00, 8'h01, 4'd7},  // R7 status shows ready
    {3'd1, 1'b0, 2'd0, 8'h00, 8'hA5, 4'd7},  // R7 data-out on bus
    {3'd1, 1'b0, 2'd1, 8'h00, 8'h00, 4'd9},  // R9 ready cleared by read
    {3'd0, 1'b1, 2'd0, 8'h3E, 8'h00, 4'd5},  // R5 mux write, data bit1 set
    {3'd3, 1'b0, 2'd0, 8'h00, 8'h3E, 4'd3},  // R3 data-in
    {3'd0, 1'b1, 2'd1, 8'h5C, 8'h00, 4'd5},  // R5 mux command write
    {3'd3, 1'b0, 2'd1, 8'h00, 8'h5C, 4'd4},  // R4 command reg
    {3'd3, 1'b0, 2'd2, 8'h00, 8'h02, 4'd4},  // R4 pending set
    {3'd1, 1'b1, 2'd1, 8'h00, 8'h02, 4'd5},  // R5 mux status read
    {3'd2, 1'b0, 2'd2, 8'h03, 8'h00, 4'd10}, // R10 irq on, clear pend
    {3'd3, 1'b0, 2'd2, 8'h00, 8'h04, 4'd10}, // R10
    {3'd1, 1'b0, 2'd1, 8'h00, 8'h04, 4'd7},  // R7 irq in status
    {3'd0, 1'b0, 2'd0, 8'hC3, 8'h00, 4'd6},  // R6 demux data write
    {3'd3, 1'b0, 2'd0, 8'h00, 8'hC3, 4'd6},  // R6
    {3'd0, 1'b0, 2'd1, 8'h81, 8'h00, 4'd6},  // R6 demux command write
    {3'd3, 1'b0, 2'd1, 8'h00, 8'h81, 4'd6},  // R6
    {3'd2, 1'b0, 2'd2, 8'h00, 8'h00, 4'd10}, // R10 irq off, pend kept
    {3'd3, 1'b0, 2'd3, 8'h00, 8'h00, 4'd11}  // R11 unused address
  };

  task automatic chk(input int req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic addr_phase(input logic m, input logic s);
    mux_mode = m;
    if (m) begin
      bus_din = {6'b0, s, 1'b0};
      bus_ale = 1'b1; clks(4);
      bus_ale = 1'b0; clks(4);
    end else begin
      bus_ale = s;
    end
  endtask

  task automatic m_write(input logic m, input logic s, input logic [7:0] d, input logic cs);
    addr_phase(m, s);
    bus_cs_n = !cs; bus_din = d; bus_wr_n = 1'b0; clks(4);
    bus_wr_n = 1'b1; clks(4);
    bus_cs_n = 1'b1; bus_ale = 1'b0; clks(4);
  endtask

  task automatic m_read(input logic m, input logic s, input logic cs, output logic [7:0] v, output logic oe);
    addr_phase(m, s);
    bus_cs_n = !cs; bus_rd_n = 1'b0; clks(6);
    v = bus_dout; oe = bus_oe;
    bus_rd_n = 1'b1; clks(3);
    bus_cs_n = 1'b1; bus_ale = 1'b0; clks(4);
  endtask

  task automatic c_write(input logic [1:0] a, input logic [7:0] d);
    core_addr = a; core_wdata = d; core_wr = 1'b1; clks(1);
    core_wr = 1'b0; clks(1);
  endtask

  task automatic c_read(input logic [1:0] a, output logic [7:0] v);
    core_addr = a; clks(1);
    v = core_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic oe;
    clks(4);
    rst = 1'b0;
    clks(1);
    // R1 reset state
    chk(1, {7'b0, host_irq}, 8'h00);
    chk(1, {7'b0, bus_oe}, 8'h00);
    chk(1, core_rdata, 8'h00);
    c_read(2'd2, v); chk(1, v, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      logic m;
      logic [1:0] s;
      logic [7:0] d, e;
      int rq;
      op = VEC[i][25:23]; m = VEC[i][22]; s = VEC[i][21:20];
      d = VEC[i][19:12]; e = VEC[i][11:4]; rq = int'(VEC[i][3:0]);
      case (op)
        3'd0: m_write(m, s[0], d, 1'b1);
        3'd1: begin
          m_read(m, s[0], 1'b1, v, oe);
          chk(8, {7'b0, oe}, 8'h01);
          chk(rq, v, e);
        end
        3'd2: c_write(s, d);
        default: begin
          c_read(s, v);
          chk(rq, v, e);
        end
      endcase
    end

    // R10 status after clearing irq keeps pend, host_irq low at port
    c_read(2'd2, v); chk(10, v, 8'h02);
    chk(10, {7'b0, host_irq}, 8'h00);
    c_write(2'd2, 8'h01); clks(1);
    chk(10, {7'b0, host_irq}, 8'h01);

    // R8 output enable gating
    bus_cs_n = 1'b1; bus_rd_n = 1'b0; #1;
    chk(8, {7'b0, bus_oe}, 8'h00);
    bus_cs_n = 1'b0; bus_rd_n = 1'b1; #1;
    chk(8, {7'b0, bus_oe}, 8'h00);
    bus_cs_n = 1'b1; clks(4);

    // R2 strobes without chip select
    m_write(1'b0, 1'b0, 8'h99, 1'b0);
    c_read(2'd0, v); chk(2, v, 8'hC3);
    m_write(1'b0, 1'b1, 8'h77, 1'b0);
    c_read(2'd1, v); chk(2, v, 8'h81);
    c_write(2'd0, 8'h11);
    m_read(1'b0, 1'b0, 1'b0, v, oe);
    chk(2, {7'b0, oe}, 8'h00);
    c_read(2'd2, v); chk(2, v, 8'h07);

    // R5 data-phase bit1 flip does not move latched select
    m_write(1'b1, 1'b1, 8'h02, 1'b1);
    c_read(2'd1, v); chk(5, v, 8'h02);
    c_read(2'd0, v); chk(5, v, 8'hC3);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule